// File: doc/BRIEF.md
# Directional Segmented Track Switch Block

This block is the switch block of one tile in a mesh of programmable logic. Four sides (north, east, south, west) each carry `W` incoming and `W` outgoing one-bit track wires. Every outgoing wire has exactly one driver, which is a multiplexer inside this block. No tristate or bidirectional drivers exist. A multiplexer only ever chooses among incoming wires that share its own track index, so a signal stays in its track domain from the moment it enters the network. The number of switch points therefore grows linearly with `W`. Logic block outputs enter the network through these same multiplexers, at tiles where a wire segment starts.

Wires are segmented with length `LSEG`, and segment starts are staggered across tracks. At a start tile, the outgoing wire has a full multiplexer: the three other sides plus the logic block outputs. At an intermediate tile, the wire is hardwired straight through when `CORNER_TURN` is 0. When `CORNER_TURN` is 1, it gets a small two-candidate multiplexer instead, so a perpendicular signal can turn onto it. Routing is loaded through a serial shift chain that can also be read back. The datapath is purely combinational.

The data here is not a stream, so there is no valid/ready interface; all pins are plain level signals.

Top module: `sb_switch_block`

## Requirements
- R1: After reset, the whole configuration is zero, so every multiplexed output is 0 whatever its inputs.
- R2: While `cfg_en` is high, the chain shifts one bit per clock, with `cfg_in` entering at the top. After 4·W·SELW shifts, the first bit shifted in sits at bit 0. Output k = side·W + track reads its select code from bits [k·SELW +: SELW], LSB first. Sides are N=0, E=1, S=2, W=3, and SELW = ceil(log2(NLB+4)).
- R3: `cfg_out` presents bit 0 of the chain. Shifting a new configuration in therefore returns the previous one on `cfg_out`, in the order it was loaded.
- R4: While `cfg_en` is high, every multiplexed output is 0.
- R5: With `cfg_en` low, the configuration does not change, whatever `cfg_in` does.
- R6: At a start tile, output (s,i) takes incoming track i from a side selected by the code. Code 1 selects side (s+1) mod 4, code 2 selects (s+2) mod 4, and code 3 selects (s+3) mod 4.
- R7: At a start tile, codes 4 to 3+NLB select logic block output `lb_src[code-4]`.
- R8: Code 0 means undriven, and so does any code above the output's candidate count. An undriven output is 0.
- R9: Track i starts a segment at this tile when (coord + i) mod LSEG == 0. The coord is TILE_X for east/west tracks and TILE_Y for north/south tracks.
- R10: With CORNER_TURN = 0, an output at an intermediate tile equals incoming track i from the opposite side. This holds regardless of configuration and `cfg_en`.
- R11: With CORNER_TURN = 1, an output (s,i) at an intermediate tile uses three codes. Code 1 passes straight from side (s+2) mod 4, code 2 turns in from side (s+1) mod 4, and any other code gives 0.
- R12: An input on track index i never reaches an output of a different index.
- R13: Outputs follow input changes in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, clears the configuration |
| cfg_en | input | 1 | Shift enable for the chain; forces multiplexed outputs to 0 |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Serial readback, bit 0 of the chain |
| trk_in | input | 4*W | Incoming tracks, index side*W + track |
| lb_src | input | NLB | Logic block outputs offered at segment starts |
| trk_out | output | 4*W | Outgoing tracks, index side*W + track |

## Verification
Track outputs are combinational. The bench changes `trk_in` or `lb_src` and samples one time unit later, with no clock edge in between. Configuration bits move only on rising edges. The bench drives `cfg_in` and `cfg_en` on falling edges, so a full load takes exactly 4·W·SELW rising edges. It compares `cfg_out` against the previous load just before each of those edges, because bit j of the old configuration sits at bit 0 after j shifts. Outputs are compared only after `cfg_en` has been lowered at a falling edge, since the release of the hold is itself combinational.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NSIDE = 4;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  function automatic int rot_side(input int s, input int step);
    return (s + step) % NSIDE;
  endfunction

  function automatic bit is_horiz(input int s);
    return (s == int'(SIDE_E)) || (s == int'(SIDE_W));
  endfunction
endpackage

// File: rtl/sb_cfg_chain.sv
module sb_cfg_chain #(
  parameter int LEN = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           bit_in,
  output logic           bit_out,
  output logic [LEN-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (shift_en) q <= {bit_in, q[LEN-1:1]};
  end

  assign bit_out = q[0];

  // R2: new bit lands at the top of the chain one edge later
  p_shift_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[LEN-1] == $past(bit_in));
  // R2: the remaining bits move down by one position
  p_shift_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[LEN-2:0] == $past(q[LEN-1:1]));
  // R5: configuration frozen while not shifting
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/sb_out_mux.sv
module sb_out_mux #(
  parameter int NCAND = 5,
  parameter int SELW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [SELW-1:0]  sel,
  input  logic [NCAND-1:0] cand,
  output logic             y
);
  always_comb begin
    y = 1'b0;
    if (!hold) begin
      for (int c = 0; c < NCAND; c++) begin
        if (sel == SELW'(c + 1)) y = cand[c];
      end
    end
  end

  // R8: code 0 never drives a 1
  p_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !y);
  // R4: outputs held low during configuration
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !y);
  // R12: a 1 can only come from a same-index candidate
  p_domain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    y |-> (|cand));
endmodule

// File: rtl/sb_switch_block.sv
module sb_switch_block
  import sb_pkg::*;
#(
  parameter int W           = 4,
  parameter int LSEG        = 2,
  parameter int NLB         = 2,
  parameter int TILE_X      = 0,
  parameter int TILE_Y      = 1,
  parameter bit CORNER_TURN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_in,
  output logic                 cfg_out,
  input  logic [NSIDE*W-1:0]   trk_in,
  input  logic [NLB-1:0]       lb_src,
  output logic [NSIDE*W-1:0]   trk_out
);
  localparam int NSTART = 3 + NLB;
  localparam int SELW   = $clog2(NSTART + 1);
  localparam int NOUT   = NSIDE * W;
  localparam int TOT    = NOUT * SELW;

  logic [TOT-1:0] cfg_q;

  sb_cfg_chain #(.LEN(TOT)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(cfg_en),
    .bit_in  (cfg_in),
    .bit_out (cfg_out),
    .q       (cfg_q)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    for (genvar i = 0; i < W; i++) begin : g_trk
      localparam int K     = s * W + i;
      localparam int CRD   = is_horiz(s) ? TILE_X : TILE_Y;
      localparam bit START = ((CRD + i) % LSEG) == 0;
      localparam int S1    = rot_side(s, 1);
      localparam int S2    = rot_side(s, 2);
      localparam int S3    = rot_side(s, 3);

      logic [SELW-1:0] fld;
      assign fld = cfg_q[K*SELW +: SELW];

      if (START) begin : g_start
        logic [NSTART-1:0] cand;
        assign cand = {lb_src, trk_in[S3*W+i], trk_in[S2*W+i], trk_in[S1*W+i]};
        sb_out_mux #(.NCAND(NSTART), .SELW(SELW)) u_mux (
          .clk(clk), .rst_n(rst_n), .hold(cfg_en),
          .sel(fld), .cand(cand), .y(trk_out[K])
        );
      end else if (CORNER_TURN) begin : g_turn
        logic [1:0] cand;
        assign cand = {trk_in[S1*W+i], trk_in[S2*W+i]};
        sb_out_mux #(.NCAND(2), .SELW(SELW)) u_mux (
          .clk(clk), .rst_n(rst_n), .hold(cfg_en),
          .sel(fld), .cand(cand), .y(trk_out[K])
        );
      end else begin : g_pass
        logic unused_fld;
        assign unused_fld = ^fld;
        assign trk_out[K] = trk_in[S2*W+i];
        // R10: hardwired segment continuation
        p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
          trk_out[K] == trk_in[S2*W+i]);
      end
    end
  end
endmodule

// File: tb/tb_sb_switch_block.sv
module tb_sb_switch_block;
  localparam int W = 4, LSEG = 2, NLB = 2, TX = 0, TY = 1;
  localparam int SELW = $clog2(3 + NLB + 1);
  localparam int NOUT = 4 * W;
  localparam int TOT  = NOUT * SELW;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_in = 1'b0;
  logic [NOUT-1:0] trk_in = '0;
  logic [NLB-1:0]  lb_src = '0;
  logic cfg_out, cfg_out_nc;
  logic [NOUT-1:0] trk_out, trk_out_nc;
  logic [TOT-1:0] cur_cfg = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sb_switch_block #(.W(W), .LSEG(LSEG), .NLB(NLB), .TILE_X(TX), .TILE_Y(TY),
    .CORNER_TURN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .trk_in(trk_in), .lb_src(lb_src), .trk_out(trk_out));

  sb_switch_block #(.W(W), .LSEG(LSEG), .NLB(NLB), .TILE_X(TX), .TILE_Y(TY),
    .CORNER_TURN(1'b0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out_nc),
    .trk_in(trk_in), .lb_src(lb_src), .trk_out(trk_out_nc));

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // Reference model written from R6..R11
  function automatic logic model(input int s, input int i, input bit corner);
    int crd, code;
    bit start;
    crd   = (s == 1 || s == 3) ? TX : TY;
    start = ((crd + i) % LSEG) == 0;
    code  = int'(cur_cfg[(s*W+i)*SELW +: SELW]);
    if (!start && !corner) return trk_in[((s+2)%4)*W+i];
    if (cfg_en) return 1'b0;
    if (start) begin
      if (code >= 1 && code <= 3) return trk_in[((s+code)%4)*W+i];
      if (code >= 4 && code <= 3 + NLB) return lb_src[code-4];
      return 1'b0;
    end
    if (code == 1) return trk_in[((s+2)%4)*W+i];
    if (code == 2) return trk_in[((s+1)%4)*W+i];
    return 1'b0;
  endfunction

  task automatic check_all(input string req);
    #1;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < W; i++) begin
        chk(trk_out[s*W+i], model(s, i, 1'b1), req, $sformatf("dut out s%0d t%0d", s, i));
        chk(trk_out_nc[s*W+i], model(s, i, 1'b0), req, $sformatf("dut_nc out s%0d t%0d", s, i));
      end
  endtask

  task automatic load(input logic [TOT-1:0] v);
    int bad = 0;
    for (int j = 0; j < TOT; j++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = v[j];
      #1;
      // R3: old configuration streams out in load order
      if (cfg_out !== cur_cfg[j] || cfg_out_nc !== cur_cfg[j]) bad++;
    end
    chk(bad == 0, 1'b1, "R3", "readback mismatches during load");
    @(negedge clk);
    cfg_en = 1'b0;
    cur_cfg = v;
  endtask

  function automatic logic [TOT-1:0] set_code(input logic [TOT-1:0] v, input int s,
                                               input int i, input int code);
    v[(s*W+i)*SELW +: SELW] = SELW'(code);
    return v;
  endfunction

  task automatic t_reset();
    trk_in = '1; lb_src = '1;
    check_all("R1");
    // mid tiles with hardwired pass still pass a 1 (R10), all multiplexed outputs 0
    for (int k = 0; k < NOUT; k++) chk(trk_out[k], 1'b0, "R1", $sformatf("reset out %0d", k));
  endtask

  task automatic t_field_order();
    // R2: single bit 0 first -> field 0 (north, track 0, mid tile) code 1 = straight from south
    logic [TOT-1:0] v = '0;
    v[0] = 1'b1;
    load(v);
    trk_in = '0; trk_in[2*W+0] = 1'b1; lb_src = '0;
    #1 chk(trk_out[0], 1'b1, "R2", "first shifted bit selects field 0");
    check_all("R2");
  endtask

  task automatic t_sides();
    // R6 and R9: each start output uses each side code in turn
    for (int code = 1; code <= 3; code++) begin
      logic [TOT-1:0] v = '0;
      for (int k = 0; k < NOUT; k++) v = set_code(v, k / W, k % W, code);
      load(v);
      for (int p = 0; p < 4; p++) begin
        trk_in = NOUT'(16'h1 << (p * 4)) | NOUT'(16'h5 << p);
        check_all("R6");
      end
      trk_in = 16'hA5C3; check_all("R9");
    end
  endtask

  task automatic t_lb();
    logic [TOT-1:0] v = '0;
    for (int k = 0; k < NOUT; k++) v = set_code(v, k / W, k % W, 4 + (k % NLB));
    load(v);
    trk_in = '1;
    for (int m = 0; m < 4; m++) begin
      lb_src = NLB'(m);
      check_all("R7");
    end
  endtask

  task automatic t_illegal();
    logic [TOT-1:0] v = '0;
    for (int k = 0; k < NOUT; k++) v = set_code(v, k / W, k % W, (k % 2) ? 7 : 6);
    load(v);
    trk_in = '1; lb_src = '1;
    check_all("R8");
    for (int k = 0; k < NOUT; k++) chk(trk_out[k], 1'b0, "R8", $sformatf("illegal code out %0d", k));
  endtask

  task automatic t_hold();
    logic [TOT-1:0] v = '0;
    for (int k = 0; k < NOUT; k++) v = set_code(v, k / W, k % W, 1 + (k % 2));
    load(v);
    trk_in = '1; lb_src = '1;
    @(negedge clk);
    cfg_en = 1'b1; cfg_in = cur_cfg[0];
    check_all("R4");
    for (int k = 0; k < NOUT; k++) chk(trk_out[k], 1'b0, "R4", $sformatf("held out %0d", k));
    // undo the one shift by completing a full rotation of the same vector
    for (int j = 1; j < TOT; j++) begin
      @(negedge clk); cfg_in = cur_cfg[j];
    end
    @(negedge clk); cfg_en = 1'b0;
    check_all("R4");
  endtask

  task automatic t_keep();
    for (int c = 0; c < 20; c++) begin
      @(negedge clk); cfg_in = ~cfg_in;
    end
    trk_in = 16'h3C96; lb_src = 2'b10;
    check_all("R5");
  endtask

  task automatic t_corner();
    logic [TOT-1:0] v = '0;
    for (int k = 0; k < NOUT; k++) v = set_code(v, k / W, k % W, 2);
    load(v);
    for (int p = 0; p < 4; p++) begin
      trk_in = NOUT'(16'hF << (p * 4));
      check_all("R11");
    end
    trk_in = 16'h00F0; check_all("R10");
  endtask

  task automatic t_domain();
    for (int i = 0; i < W; i++) begin
      logic [TOT-1:0] v;
      for (int k = 0; k < TOT; k++) v[k] = 1'($urandom_range(0, 1));
      for (int k = 0; k < NOUT; k++)
        v = set_code(v, k / W, k % W, int'($urandom_range(0, 3)));
      load(v);
      lb_src = '0; trk_in = '0;
      for (int s = 0; s < 4; s++) trk_in[s*W+i] = 1'b1;
      #1;
      for (int k = 0; k < NOUT; k++)
        if (k % W != i) chk(trk_out[k] | trk_out_nc[k], 1'b0, "R12",
                            $sformatf("index %0d leaked to out %0d", i, k));
      check_all("R12");
    end
  endtask

  task automatic t_random();
    for (int r = 0; r < 6; r++) begin
      logic [TOT-1:0] v;
      for (int k = 0; k < NOUT; k++)
        v[k*SELW +: SELW] = SELW'($urandom_range(0, 3 + NLB));
      load(v);
      for (int p = 0; p < 8; p++) begin
        trk_in = NOUT'($urandom); lb_src = NLB'($urandom);
        check_all("R13");
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_field_order();
    t_sides();
    t_lb();
    t_illegal();
    t_hold();
    t_keep();
    t_corner();
    t_domain();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule